// File: doc/BRIEF.md
# Triggered Multi-Frame Stream Capture

This block records a burst of complex receive samples after a software trigger and sends it as 128-bit stream beats to a downstream DMA engine. Each input clock presents four complex samples. A sample is a 16-bit signed in-phase value and a 16-bit signed quadrature value in Q1.15, and it fills one 32-bit lane. The length of the burst is set in frames of 512 samples. Software programs the frame count, from 1 to 1024, before it pulses the trigger. The block stops on the exact last beat and marks that beat with TLAST.

A two-bit source select picks the beat contents. The choices are the processed live input, an unprocessed bypass input, or a built-in counter pattern. In the counter pattern, the real half of each lane holds the sample position inside the current frame. The imaginary half holds the frame number. Software can use this pattern to confirm sample and lane order after the DMA transfer. A busy output and a done output let the control side follow the state of the capture.

Top module: `burst_capture`

## Requirements
- R1: After reset, m_tvalid, busy and done are all low.
- R2: A trigger pulse sampled while the block is not busy, with frame_count in 1..1024, starts a capture. busy is high on the next cycle, and done is cleared at the same edge.
- R3: Lane k (k = 0..3) occupies m_tdata[32k+31:32k], so the lowest sample index sits in the least significant lane. Within a lane, the real (I) half is bits [31:16] and the imaginary (Q) half is bits [15:0].
- R4: With src_sel[1] = 1 (counter pattern), lane k of beat b within frame f carries I = 4b + k and Q = f. Both values are zero-extended. Both counters restart from zero on each accepted trigger. The sample index returns to 0 at each frame boundary, and the frame index then increments.
- R5: A capture emits exactly frame_count × 128 beats. m_tlast is high only on the final one.
- R6: While m_tvalid is high and m_tready is low, m_tdata and m_tlast hold their values, and the counters do not advance.
- R7: A trigger that arrives while busy is high has no effect on the running capture.
- R8: frame_count is latched when a capture starts. Changing it during a capture does not change that capture's length.
- R9: A trigger with frame_count equal to 0 or above 1024 is ignored, and busy stays low.
- R10: src_sel = 0 forwards live_data and src_sel = 1 forwards bypass_data. Each value is captured at the cycle in which it is taken.
- R11: busy stays high from the start of a capture until its final beat is accepted. done then rises and stays high until the next accepted trigger. busy and done are never high together.
- R12: In the live and bypass modes, a beat is taken only in a cycle with in_valid high. In counter mode, in_valid is ignored. Any beat that arrives outside a capture, or while the output register is stalled, is not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Single-cycle capture start pulse |
| src_sel | input | 2 | 0 live, 1 bypass, 2 or 3 counter pattern |
| frame_count | input | 11 | Frames per capture, 1..1024 |
| in_valid | input | 1 | Input beat present on live_data and bypass_data |
| live_data | input | 128 | Four processed complex samples |
| bypass_data | input | 128 | Four unprocessed complex samples |
| m_tready | input | 1 | Stream sink ready |
| m_tvalid | output | 1 | Stream beat valid |
| m_tdata | output | 128 | Stream beat, four 32-bit lanes |
| m_tlast | output | 1 | Final beat of the capture |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Last capture completed |

## Verification
The bench aims at the final beat of a capture. A design with an off-by-one end condition would add or drop a beat, or would set TLAST one beat early. The bench also runs the largest count of 1024 frames, where a frame counter one bit too narrow would wrap and send the imaginary parts back to zero. Random back-pressure tests whether a stalled beat stays stable and whether the counters hold. A design that advanced during a stall would skip sample indices. Further tests pulse the trigger and rewrite frame_count in the middle of a capture, and try counts of 0 and 1025. These expose a block that restarts on a second trigger or runs a capture of the wrong length.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    SRC_LIVE   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_CNT_A  = 2'd2,
    SRC_CNT_B  = 2'd3
  } cap_src_e;

  function automatic logic src_is_counter(input logic [1:0] sel);
    return sel[1];
  endfunction
endpackage

// File: rtl/cap_sequencer.sv
module cap_sequencer #(
  parameter int FRAME_BEATS = 128,
  parameter int MAX_FRAMES  = 1024,
  localparam int BEAT_W = $clog2(FRAME_BEATS),
  localparam int FRM_W  = $clog2(MAX_FRAMES),
  localparam int FC_W   = $clog2(MAX_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [FC_W-1:0]   fc_in,
  input  logic              advance,
  output logic              run,
  output logic [BEAT_W-1:0] beat_idx,
  output logic [FRM_W-1:0]  frame_idx,
  output logic              is_last
);
  localparam logic [BEAT_W-1:0] BEAT_MAX = BEAT_W'(FRAME_BEATS - 1);

  logic              run_n;
  logic [BEAT_W-1:0] beat_n;
  logic [FRM_W-1:0]  frame_n;
  logic [FC_W-1:0]   fc_q;
  logic              end_of_frame;

  assign end_of_frame = (beat_idx == BEAT_MAX);
  assign is_last      = end_of_frame && ({1'b0, frame_idx} == FC_W'(fc_q - 1'b1));

  always_comb begin
    run_n   = run;
    beat_n  = beat_idx;
    frame_n = frame_idx;
    if (start) begin
      run_n   = 1'b1;
      beat_n  = '0;
      frame_n = '0;
    end else if (advance) begin
      if (end_of_frame) begin
        beat_n = '0;
        if (is_last) run_n = 1'b0;
        else         frame_n = frame_idx + 1'b1;
      end else begin
        beat_n = beat_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      beat_idx  <= '0;
      frame_idx <= '0;
    end else begin
      run       <= run_n;
      beat_idx  <= beat_n;
      frame_idx <= frame_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fc_q <= '0;
    else if (start) fc_q <= fc_in;
  end
endmodule

// File: rtl/cap_pattern.sv
module cap_pattern #(
  parameter int LANES     = 4,
  parameter int SAMP_W    = 16,
  parameter int FRAME_LEN = 512,
  parameter int BEAT_W    = 7,
  parameter int FRM_W     = 10,
  localparam int IDX_W    = $clog2(FRAME_LEN),
  localparam int DW       = LANES * 2 * SAMP_W
) (
  input  logic [BEAT_W-1:0] beat_idx,
  input  logic [FRM_W-1:0]  frame_idx,
  output logic [DW-1:0]     pattern
);
  logic [IDX_W-1:0] base;
  assign base = IDX_W'(beat_idx) * IDX_W'(LANES);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IDX_W-1:0] sidx;
    assign sidx = base + IDX_W'(k);
    assign pattern[2*SAMP_W*k +: 2*SAMP_W] = {SAMP_W'(sidx), SAMP_W'(frame_idx)};
  end
endmodule

// File: rtl/cap_outreg.sv
module cap_outreg #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          lin,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          last
);
  logic valid_n;

  always_comb begin
    valid_n = valid;
    if (load)       valid_n = 1'b1;
    else if (ready) valid_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= 1'b0;
    else        valid <= valid_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      last <= 1'b0;
    end else if (load) begin
      data <= din;
      last <= lin;
    end
  end
endmodule

// File: rtl/burst_capture.sv
module burst_capture #(
  parameter int LANES      = 4,
  parameter int SAMP_W     = 16,
  parameter int FRAME_LEN  = 512,
  parameter int MAX_FRAMES = 1024,
  localparam int DW          = LANES * 2 * SAMP_W,
  localparam int FRAME_BEATS = FRAME_LEN / LANES,
  localparam int BEAT_W      = $clog2(FRAME_BEATS),
  localparam int FRM_W       = $clog2(MAX_FRAMES),
  localparam int FC_W        = $clog2(MAX_FRAMES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trigger,
  input  logic [1:0]      src_sel,
  input  logic [FC_W-1:0] frame_count,
  input  logic            in_valid,
  input  logic [DW-1:0]   live_data,
  input  logic [DW-1:0]   bypass_data,
  input  logic            m_tready,
  output logic            m_tvalid,
  output logic [DW-1:0]   m_tdata,
  output logic            m_tlast,
  output logic            busy,
  output logic            done
);
  import cap_pkg::*;

  logic              run;
  logic              start;
  logic              advance;
  logic              avail;
  logic              is_last;
  logic              count_ok;
  logic [BEAT_W-1:0] beat_idx;
  logic [FRM_W-1:0]  frame_idx;
  logic [DW-1:0]     pattern;
  logic [DW-1:0]     beat_sel;
  logic              done_n;

  assign busy     = run | m_tvalid;
  assign count_ok = (frame_count != '0) && (frame_count <= FC_W'(MAX_FRAMES));
  assign start    = trigger && !busy && count_ok;
  assign avail    = src_is_counter(src_sel) || in_valid;
  assign advance  = run && avail && (!m_tvalid || m_tready);

  cap_sequencer #(.FRAME_BEATS(FRAME_BEATS), .MAX_FRAMES(MAX_FRAMES)) u_seq (
    .clk, .rst_n, .start, .fc_in(frame_count), .advance,
    .run, .beat_idx, .frame_idx, .is_last
  );

  cap_pattern #(.LANES(LANES), .SAMP_W(SAMP_W), .FRAME_LEN(FRAME_LEN),
                .BEAT_W(BEAT_W), .FRM_W(FRM_W)) u_pat (
    .beat_idx, .frame_idx, .pattern
  );

  always_comb begin
    unique case (cap_src_e'(src_sel))
      SRC_LIVE:   beat_sel = live_data;
      SRC_BYPASS: beat_sel = bypass_data;
      default:    beat_sel = pattern;
    endcase
  end

  cap_outreg #(.DW(DW)) u_out (
    .clk, .rst_n, .load(advance), .din(beat_sel), .lin(is_last),
    .ready(m_tready), .valid(m_tvalid), .data(m_tdata), .last(m_tlast)
  );

  always_comb begin
    done_n = done;
    if (start)                            done_n = 1'b0;
    else if (m_tvalid && m_tready && m_tlast) done_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= done_n;
  end
endmodule

// File: rtl/cap_checker.sv
module cap_checker #(
  parameter int DW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trigger,
  input logic          m_tvalid,
  input logic          m_tready,
  input logic [DW-1:0] m_tdata,
  input logic          m_tlast,
  input logic          busy,
  input logic          done
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast));

  // R11
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> busy);

  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5
  last_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready && m_tlast |=> done && !busy);

  // R7
  retrigger_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && trigger && !(m_tvalid && m_tready && m_tlast) |=> busy && !done);
endmodule

bind burst_capture cap_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trigger(trigger), .m_tvalid(m_tvalid),
  .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast),
  .busy(busy), .done(done)
);

// File: tb/burst_capture_test.sv
module burst_capture_test;
  logic         clk;
  logic         rst_n;
  logic         trigger;
  logic [1:0]   src_sel;
  logic [10:0]  frame_count;
  logic         in_valid;
  logic [127:0] live_data;
  logic [127:0] bypass_data;
  logic         m_tready;
  logic         m_tvalid;
  logic [127:0] m_tdata;
  logic         m_tlast;
  logic         busy;
  logic         done;

  burst_capture uut (
    .clk, .rst_n, .trigger, .src_sel, .frame_count, .in_valid,
    .live_data, .bypass_data, .m_tready, .m_tvalid, .m_tdata, .m_tlast,
    .busy, .done
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ready_mode = 0;
  int valid_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // behavioural reference state
  bit           mvalid, mlast, mrun, mdone;
  logic [127:0] mdata;
  int           ms, mf, mn;

  // observation state
  int           beats, lasts;
  bit           pvalid, pready;
  logic [127:0] pdata;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mvalid = 0; mlast = 0; mrun = 0; mdone = 0; mdata = '0;
      ms = 0; mf = 0; mn = 0;
    end else begin
      bit old_hs_last;
      old_hs_last = mvalid && m_tready && mlast;
      if (trigger && !(mrun || mvalid) && frame_count >= 1 && frame_count <= 1024) begin
        mrun = 1; ms = 0; mf = 0; mn = frame_count; mdone = 0;
      end else begin
        if (mrun && (!mvalid || m_tready) && (src_sel[1] || in_valid)) begin
          if (src_sel == 2'd0)      mdata = live_data;
          else if (src_sel == 2'd1) mdata = bypass_data;
          else
            for (int k = 0; k < 4; k++)
              mdata[32*k +: 32] = {16'(ms + k), 16'(mf)};
          mlast  = (mf == mn - 1) && (ms == 508);
          mvalid = 1;
          if (mlast) mrun = 0;
          ms += 4;
          if (ms == 512) begin ms = 0; mf++; end
        end else if (m_tready) begin
          mvalid = 0;
        end
        if (old_hs_last) mdone = 1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 199000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 199000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    chk(m_tvalid == mvalid, "R12 tvalid", 128'(m_tvalid), 128'(mvalid));
    if (mvalid) begin
      chk(m_tdata == mdata, src_sel[1] ? ((mdata[15:0] != 0 && mdata[31:16] == 0) ? "R4 frame wrap" : "R3 lanes") : "R10 source",
          m_tdata, mdata);
      chk(m_tlast == mlast, "R5 tlast", 128'(m_tlast), 128'(mlast));
    end
    chk(busy == (mrun || mvalid), "R11 busy", 128'(busy), 128'(mrun || mvalid));
    chk(done == mdone, "R11 done", 128'(done), 128'(mdone));
    if (pvalid && !pready)
      chk(m_tdata == pdata && m_tvalid, "R6 stall hold", m_tdata, pdata);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_tready = (ready_mode == 0) ? 1'b1 : lfsr[0];
    in_valid = (valid_mode == 0) ? 1'b1 : lfsr[3];
    for (int k = 0; k < 4; k++) live_data[32*k +: 32] = 32'(cyc * 4 + k);
    bypass_data = ~live_data;
    pvalid = m_tvalid; pready = m_tready; pdata = m_tdata;
    if (m_tvalid && m_tready) begin
      beats++;
      if (m_tlast) lasts++;
    end
  endtask

  task automatic run_capture(input logic [1:0] src, input int n, input int rm,
                             input int vm, input bit poke, input string tag);
    src_sel = src; frame_count = 11'(n); ready_mode = rm; valid_mode = vm;
    beats = 0; lasts = 0;
    trigger = 1'b1;
    step();
    trigger = 1'b0;
    step();
    chk(busy == 1'b1, "R2 start", 128'(busy), 128'(1));
    for (int i = 0; i < 50 && poke; i++) step();
    if (poke) begin
      trigger = 1'b1; frame_count = 11'd1;   // R7 and R8 stimulus
      step();
      trigger = 1'b0;
    end
    for (int i = 0; i < 190000 && !done; i++) step();
    step();
    chk(beats == n * 128, {tag, " beat count"}, 128'(beats), 128'(n * 128));
    chk(lasts == 1, "R5 single tlast", 128'(lasts), 128'(1));
    chk(done == 1'b1 && busy == 1'b0, "R11 end state", {busy, done}, 2'b01);
  endtask

  initial begin
    rst_n = 1'b0; trigger = 1'b0; src_sel = 2'd2; frame_count = 11'd1;
    in_valid = 1'b0; live_data = '0; bypass_data = '0; m_tready = 1'b1;
    pvalid = 0; pready = 1; pdata = '0;
    repeat (3) @(negedge clk);
    chk(m_tvalid == 0 && busy == 0 && done == 0, "R1 reset", {m_tvalid, busy, done}, 3'b000);
    rst_n = 1'b1;
    step(); step();

    run_capture(2'd2, 1, 0, 0, 0, "R5 single frame");
    run_capture(2'd3, 3, 1, 1, 0, "R6 backpressure");
    run_capture(2'd2, 2, 1, 0, 1, "R7 R8 retrigger");
    run_capture(2'd0, 1, 0, 1, 0, "R12 live gaps");
    run_capture(2'd1, 1, 1, 1, 0, "R10 bypass");

    // R9 out-of-range counts
    frame_count = 11'd0; trigger = 1'b1; step(); trigger = 1'b0; step(); step();
    chk(busy == 1'b0, "R9 zero count", 128'(busy), 128'(0));
    frame_count = 11'd1025; trigger = 1'b1; step(); trigger = 1'b0; step(); step();
    chk(busy == 1'b0, "R9 count 1025", 128'(busy), 128'(0));

    run_capture(2'd2, 1024, 0, 0, 0, "R4 max frames");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule